// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Flags

This block turns an idle-high asynchronous serial line into parallel characters. It shares its frame settings with a matching transmitter: the number of data bits (5 to 9), the parity mode (none, even or odd) and the bit rate. The bit rate comes from a 12-bit divisor and an option that halves the oversampling ratio. A falling edge on the line starts a frame. Each bit is then voted from three samples taken near its middle. The data bits are assembled least significant bit first, and the parity bit and the first stop bit are checked.

A finished character goes into a one-entry receive buffer. The buffer raises a full flag, and that flag stays up until the consumer pulses the read strobe. Three error flags travel with the buffered character: a bad stop bit, a parity mismatch, and an overrun. The overrun flag means a later character arrived while the buffer was still unread. That later character is dropped and the unread one is kept.

Top module: `async_rx`

## Requirements
- R1: After reset, rx_full, err_frame, err_overrun, err_parity, rx_bit8 and rx_data all read 0.
- R2: Data bits arrive least significant bit first. char_size 0, 1, 2 and 3 select 5, 6, 7 and 8 bits, and any value from 4 to 7 selects 9 bits. Bits of rx_data above the character width read 0. The ninth bit appears on rx_bit8, which reads 0 for narrower characters.
- R3: One bit lasts 16 sub-bit ticks, or 8 when dbl_speed is 1. One tick lasts baud_div+1 clock cycles.
- R4: Each bit value is the majority of three samples taken one tick apart around the bit centre. A disturbance shorter than one tick inside a bit does not change that bit.
- R5: A frame starts on a falling edge of the idle-high line and the start bit is voted again at its centre. A low pulse shorter than half a bit yields no character.
- R6: par_mode 2'b00 and 2'b01 mean no parity bit, 2'b10 means even parity and 2'b11 means odd parity. A parity bit that does not match sets err_parity for that character.
- R7: A first stop bit voted low sets err_frame for that character. Only the first stop bit is sampled. The receiver can accept a new start edge from the centre of that stop bit onward, so frames may follow each other with no idle gap.
- R8: rx_full rises when a character is loaded and stays 1 until rd_strobe is 1 in a cycle where rx_full is 1. rd_strobe has no effect while rx_full is 0.
- R9: When a character completes while rx_full is 1 and rd_strobe is 0, that character is discarded. err_overrun then becomes 1, while rx_data, rx_bit8, err_frame and err_parity keep their values.
- R10: Loading a character replaces all three error flags with that character's own status, so a clean character clears earlier errors.
- R11: While rx_en is 0, the receiver stays idle, any frame in progress is abandoned and no character is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| char_size | input | 3 | Data width code (see R2) |
| par_mode | input | 2 | Parity mode code (see R6) |
| baud_div | input | 12 | Tick divisor, one tick per baud_div+1 clocks |
| dbl_speed | input | 1 | Eight ticks per bit instead of sixteen |
| rxd | input | 1 | Asynchronous serial input, idle high |
| rd_strobe | input | 1 | Consumes the buffered character |
| rx_data | output | 8 | Data bits 0 to 7 of the buffered character |
| rx_bit8 | output | 1 | Ninth data bit of the buffered character |
| rx_full | output | 1 | Buffer holds an unread character |
| err_frame | output | 1 | First stop bit of the buffered character was low |
| err_overrun | output | 1 | A character was lost while the buffer was full |
| err_parity | output | 1 | Parity mismatch on the buffered character |

## Verification
A wrong bit index or a shifted sampling phase shows up on rx_data at the end of the very next frame, as a shifted or misordered character. A stuck or early state in the frame sequencer makes rx_full rise too early, too late, or not at all within one frame time. Buffer-state errors show at once at the ports: a full flag that clears without a read, or an overrun that overwrites the held data, appears on rx_full, rx_data and err_overrun in the cycle after the completing character. A flag left over from an earlier character is seen on the following clean character.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   // number of data bits selected by the size code
   function automatic logic [3:0] data_bits(input logic [2:0] code);
      return code[2] ? 4'd9 : (4'd5 + {2'b00, code[1:0]});
   endfunction

endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[gi] <= 1'b1;
               else        chain[gi] <= din;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[gi] <= 1'b1;
               else        chain[gi] <= chain[gi-1];
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/async_rx_baud.sv
module async_rx_baud #(
   parameter int DIV_W   = 12,
   parameter int OS_NORM = 16,
   parameter int OS_FAST = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   input  logic             dbl,
   output logic             smp_ev,
   output logic             vote_ev
);
   localparam int SUB_W = $clog2(OS_NORM);
   localparam logic [SUB_W-1:0] MID_N  = SUB_W'(OS_NORM / 2);
   localparam logic [SUB_W-1:0] MID_F  = SUB_W'(OS_FAST / 2);
   localparam logic [SUB_W-1:0] LAST_N = SUB_W'(OS_NORM - 1);
   localparam logic [SUB_W-1:0] LAST_F = SUB_W'(OS_FAST - 1);

   logic [DIV_W-1:0] cnt;
   logic [SUB_W-1:0] sub;
   logic             tick;
   logic [SUB_W-1:0] mid, last;

   assign tick = (cnt == '0);
   assign mid  = dbl ? MID_F  : MID_N;
   assign last = dbl ? LAST_F : LAST_N;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sub <= '0;
      end else if (restart) begin
         cnt <= div;
         sub <= '0;
      end else if (tick) begin
         cnt <= div;
         sub <= (sub == last) ? '0 : sub + 1'b1;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

   assign smp_ev  = tick && ((sub == mid - 1'b1) || (sub == mid));
   assign vote_ev = tick && (sub == mid + 1'b1);

   // R3: a non-zero divisor never yields two ticks in a row
   a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> !tick);
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
   import async_rx_pkg::*;
#(
   parameter bit MAJORITY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [2:0] size_code,
   input  logic [1:0] pmode,
   input  logic       rxs,
   input  logic       smp_ev,
   input  logic       vote_ev,
   output logic       restart,
   output logic       done,
   output logic [8:0] word,
   output logic       fe,
   output logic       pe
);
   rx_state_e  state;
   logic [3:0] idx;
   logic [3:0] nbits;
   logic       acc, prev, vote;
   logic [1:0] smp;

   assign nbits = data_bits(size_code);

   generate
      if (MAJORITY) begin : g_vote3
         assign vote = (smp[1] & smp[0]) | (smp[1] & rxs) | (smp[0] & rxs);
      end else begin : g_vote1
         assign vote = smp[0];
      end
   endgenerate

   assign restart = en && (state == ST_IDLE) && prev && !rxs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
         acc   <= 1'b0;
         prev  <= 1'b1;
         smp   <= '0;
         done  <= 1'b0;
         word  <= '0;
         fe    <= 1'b0;
         pe    <= 1'b0;
      end else begin
         done <= 1'b0;
         prev <= rxs;
         if (smp_ev) smp <= {smp[0], rxs};
         if (!en) begin
            state <= ST_IDLE;
         end else begin
            unique case (state)
               ST_IDLE: if (restart) begin
                  state <= ST_START;
                  word  <= '0;
                  idx   <= '0;
                  acc   <= 1'b0;
                  pe    <= 1'b0;
               end
               ST_START: if (vote_ev) state <= vote ? ST_IDLE : ST_DATA;
               ST_DATA: if (vote_ev) begin
                  word[idx] <= vote;
                  acc       <= acc ^ vote;
                  if (idx >= nbits - 4'd1) state <= pmode[1] ? ST_PAR : ST_STOP;
                  else                     idx   <= idx + 4'd1;
               end
               ST_PAR: if (vote_ev) begin
                  pe    <= vote ^ acc ^ pmode[0];
                  state <= ST_STOP;
               end
               ST_STOP: if (vote_ev) begin
                  fe    <= !vote;
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R11: disabling the receiver returns it to idle
   a_r11_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state == ST_IDLE));
   // R7: one completion pulse per frame
   a_r7_single_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2: bit index stays inside the nine-bit word
   a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA) |-> (idx <= 4'd8));
endmodule

// File: rtl/async_rx_buf.sv
module async_rx_buf (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [8:0] in_word,
   input  logic       in_fe,
   input  logic       in_pe,
   input  logic       rd,
   output logic       full,
   output logic [8:0] word,
   output logic       fe,
   output logic       pe,
   output logic       ovr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         word <= '0;
         fe   <= 1'b0;
         pe   <= 1'b0;
         ovr  <= 1'b0;
      end else if (load) begin
         if (full && !rd) begin
            ovr <= 1'b1;
         end else begin
            word <= in_word;
            fe   <= in_fe;
            pe   <= in_pe;
            ovr  <= 1'b0;
            full <= 1'b1;
         end
      end else if (rd) begin
         full <= 1'b0;
      end
   end

   // R8: an unread character stays flagged
   a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd) |=> full);
   // R9: overrun keeps the held character
   a_r9_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (full && load && !rd) |=> (ovr && $stable(word)));
   // R10: a load clears an earlier overrun
   a_r10_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (!full || rd)) |=> (!ovr && full));
endmodule

// File: rtl/async_rx.sv
module async_rx #(
   parameter int DIV_W       = 12,
   parameter int SYNC_STAGES = 2,
   parameter int OS_NORM     = 16,
   parameter int OS_FAST     = 8,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic [2:0]       char_size,
   input  logic [1:0]       par_mode,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             dbl_speed,
   input  logic             rxd,
   input  logic             rd_strobe,
   output logic [7:0]       rx_data,
   output logic             rx_bit8,
   output logic             rx_full,
   output logic             err_frame,
   output logic             err_overrun,
   output logic             err_parity
);
   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (OS_FAST >= 4 && OS_NORM > OS_FAST) else $error("bad oversampling ratios");
      assert ((OS_NORM & (OS_NORM - 1)) == 0) else $error("OS_NORM must be a power of two");
      assert (DIV_W >= 1) else $error("DIV_W must be positive");
   end

   logic       rxs, smp_ev, vote_ev, restart, done, f_fe, f_pe;
   logic [8:0] f_word, b_word;

   async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs));

   async_rx_baud #(.DIV_W(DIV_W), .OS_NORM(OS_NORM), .OS_FAST(OS_FAST)) u_baud (
      .clk(clk), .rst_n(rst_n), .restart(restart), .div(baud_div),
      .dbl(dbl_speed), .smp_ev(smp_ev), .vote_ev(vote_ev));

   async_rx_frame #(.MAJORITY(MAJORITY)) u_frame (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .size_code(char_size),
      .pmode(par_mode), .rxs(rxs), .smp_ev(smp_ev), .vote_ev(vote_ev),
      .restart(restart), .done(done), .word(f_word), .fe(f_fe), .pe(f_pe));

   async_rx_buf u_buf (
      .clk(clk), .rst_n(rst_n), .load(done), .in_word(f_word),
      .in_fe(f_fe), .in_pe(f_pe), .rd(rd_strobe), .full(rx_full),
      .word(b_word), .fe(err_frame), .pe(err_parity), .ovr(err_overrun));

   assign rx_data = b_word[7:0];
   assign rx_bit8 = b_word[8];
endmodule

// File: tb/async_rx_bench.sv
module async_rx_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   typedef struct {
      logic [7:0] d;
      logic       b8;
      logic       fe;
      logic       pe;
      logic       ov;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic [2:0]  char_size = 3'd3;
   logic [1:0]  par_mode = 2'b00;
   logic [11:0] baud_div = 12'd3;
   logic        dbl_speed = 1'b0;
   logic        rxd = 1'b1;
   logic        rd_strobe = 1'b0;
   logic [7:0]  rx_data;
   logic        rx_bit8, rx_full, err_frame, err_overrun, err_parity;

   int   total = 0;
   int   bad = 0;
   bit   auto_rd = 1'b1;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   async_rx u_async_rx (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .char_size(char_size),
      .par_mode(par_mode), .baud_div(baud_div), .dbl_speed(dbl_speed),
      .rxd(rxd), .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_bit8(rx_bit8),
      .rx_full(rx_full), .err_frame(err_frame), .err_overrun(err_overrun),
      .err_parity(err_parity));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int bit_period();
      return (int'(baud_div) + 1) * (dbl_speed ? 8 : 16);
   endfunction

   task automatic hold(input logic v, input int n);
      rxd = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input int nb, input logic [1:0] pm);
      char_size = (nb == 9) ? 3'd4 : 3'(nb - 5);
      par_mode  = pm;
   endtask

   // driver: builds one frame on rxd and queues the expected character
   task automatic send(input logic [8:0] d, input int nb, input bit bad_par,
                       input bit bad_stop, input int nstop, input int gap,
                       input int gl_bit, input bit push, input string tag);
      int         bp;
      logic [8:0] dm;
      logic       pb;
      exp_t       e;
      bp = bit_period();
      dm = d & 9'((1 << nb) - 1);
      if (push) begin
         e.d = dm[7:0]; e.b8 = dm[8]; e.fe = bad_stop;
         e.pe = bad_par && par_mode[1]; e.ov = 1'b0; e.tag = tag;
         q.push_back(e);
      end
      hold(1'b0, bp);
      for (int i = 0; i < nb; i++) begin
         if (i == gl_bit) begin
            hold(dm[i], bp/2 - 1);
            hold(~dm[i], 3);
            hold(dm[i], bp - bp/2 - 2);
         end else begin
            hold(dm[i], bp);
         end
      end
      if (par_mode[1]) begin
         pb = (^dm) ^ par_mode[0] ^ bad_par;
         hold(pb, bp);
      end
      hold(!bad_stop, bp);
      for (int s = 1; s < nstop; s++) hold(1'b1, bp);
      if (gap > 0) hold(1'b1, gap);
   endtask

   task automatic drain(input string tag);
      for (int i = 0; i < 4000 && q.size() != 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(tag, "scoreboard empty", q.size(), 0);
   endtask

   // monitor: consumes each character and compares it with the queue head
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (auto_rd && rx_full) begin
            if (q.size() == 0) begin
               chk("R8", "unexpected character", {24'd0, rx_data}, 32'hFFFF);
            end else begin
               e = q.pop_front();
               chk(e.tag, "data",        rx_data,     e.d);
               chk(e.tag, "bit8",        rx_bit8,     e.b8);
               chk(e.tag, "err_frame",   err_frame,   e.fe);
               chk(e.tag, "err_parity",  err_parity,  e.pe);
               chk(e.tag, "err_overrun", err_overrun, e.ov);
            end
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
         end
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      total++; bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int bp;
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "rx_full",     rx_full,     0);
      chk("R1", "rx_data",     rx_data,     0);
      chk("R1", "rx_bit8",     rx_bit8,     0);
      chk("R1", "err_frame",   err_frame,   0);
      chk("R1", "err_overrun", err_overrun, 0);
      chk("R1", "err_parity",  err_parity,  0);
      rst_n = 1'b1;
      rx_en = 1'b1;
      repeat (4) @(negedge clk);
      bp = bit_period();
      hold(1'b1, bp);

      // R2 / R3: eight bits, no parity
      cfg(8, 2'b00);
      send(9'h0A5, 8, 0, 0, 1, bp, -1, 1, "R2");
      send(9'h03C, 8, 0, 0, 1, bp, -1, 1, "R3");
      // R2: narrow widths mask upper bits
      cfg(5, 2'b01);
      send(9'h1FF, 5, 0, 0, 1, bp, -1, 1, "R2");
      cfg(6, 2'b00);
      send(9'h0AA, 6, 0, 0, 1, bp, -1, 1, "R2");
      cfg(7, 2'b00);
      send(9'h155, 7, 0, 0, 1, bp, -1, 1, "R2");
      // R2: nine bits, ninth on rx_bit8
      cfg(9, 2'b00);
      send(9'h1C3, 9, 0, 0, 1, bp, -1, 1, "R2");
      send(9'h07E, 9, 0, 0, 1, bp, -1, 1, "R2");
      drain("R2");

      // R6: parity modes
      cfg(8, 2'b10);
      send(9'h0B7, 8, 0, 0, 1, bp, -1, 1, "R6");
      send(9'h0B7, 8, 1, 0, 1, bp, -1, 1, "R6");
      cfg(8, 2'b11);
      send(9'h013, 8, 0, 0, 1, bp, -1, 1, "R6");
      send(9'h013, 8, 1, 0, 1, bp, -1, 1, "R6");
      cfg(9, 2'b11);
      send(9'h101, 9, 1, 0, 1, bp, -1, 1, "R6");
      // R10: clean character after an error
      send(9'h101, 9, 0, 0, 1, bp, -1, 1, "R10");
      drain("R6");

      // R7: frame error, then a clean character clears it
      cfg(8, 2'b00);
      send(9'h0F0, 8, 0, 1, 1, bp, -1, 1, "R7");
      send(9'h00F, 8, 0, 0, 1, bp, -1, 1, "R10");
      // R7: two stop bits, then frames with no idle gap
      send(9'h066, 8, 0, 0, 2, 0, -1, 1, "R7");
      send(9'h099, 8, 0, 0, 1, 0, -1, 1, "R7");
      send(9'h0C1, 8, 0, 0, 1, bp, -1, 1, "R7");
      drain("R7");

      // R4: short disturbance inside a data bit
      send(9'h05A, 8, 0, 0, 1, bp, 3, 1, "R4");
      send(9'h0A5, 8, 0, 0, 1, bp, 6, 1, "R4");
      drain("R4");

      // R5: low pulse of a quarter bit
      hold(1'b0, bp/4);
      hold(1'b1, 3*bp);
      chk("R5", "no character after glitch", rx_full, 0);
      chk("R5", "queue", q.size(), 0);

      // R3: double-speed timing
      baud_div  = 12'd5;
      dbl_speed = 1'b1;
      bp = bit_period();
      hold(1'b1, bp);
      send(9'h0E1, 8, 0, 0, 1, bp, -1, 1, "R3");
      cfg(8, 2'b10);
      send(9'h03E, 8, 1, 0, 1, bp, -1, 1, "R3");
      drain("R3");
      baud_div  = 12'd3;
      dbl_speed = 1'b0;
      cfg(8, 2'b00);
      bp = bit_period();
      hold(1'b1, bp);

      // R9: overrun keeps the held character
      auto_rd = 1'b0;
      send(9'h011, 8, 0, 0, 1, bp, -1, 0, "R9");
      chk("R9", "first loaded", rx_full, 1);
      chk("R9", "no overrun yet", err_overrun, 0);
      send(9'h022, 8, 1, 1, 1, bp, -1, 0, "R9");
      chk("R9", "still full", rx_full, 1);
      chk("R9", "held data", rx_data, 8'h11);
      chk("R9", "overrun flag", err_overrun, 1);
      chk("R9", "frame flag kept", err_frame, 0);
      // R8: read consumes, read on empty is harmless
      rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
      chk("R8", "consumed", rx_full, 0);
      rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
      chk("R8", "read when empty", rx_full, 0);
      chk("R8", "data after empty read", rx_data, 8'h11);
      auto_rd = 1'b1;
      send(9'h033, 8, 0, 0, 1, bp, -1, 1, "R10");
      drain("R10");

      // R11: disabled receiver ignores frames and abandons a partial one
      rx_en = 1'b0;
      send(9'h044, 8, 0, 0, 1, bp, -1, 0, "R11");
      chk("R11", "nothing while disabled", rx_full, 0);
      rx_en = 1'b1;
      hold(1'b0, 3*bp);
      rx_en = 1'b0;
      hold(1'b0, 7*bp);
      hold(1'b1, 4*bp);
      rx_en = 1'b1;
      hold(1'b1, bp);
      chk("R11", "abandoned frame", rx_full, 0);
      send(9'h055, 8, 0, 0, 1, bp, -1, 1, "R11");
      drain("R11");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule